// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host reach a bank of 64 registers, each 24 bits wide, over a four-wire serial link. The host raises the select line and clocks out a single 32-bit word, most significant bit first. Data is sampled on the rising serial clock, and the clock idles low. The first bit selects write (1) or read (0). The next six bits name the register. The low 24 bits carry the payload. During a read, the block returns the addressed register within the same word, in the bit positions the payload occupies on the way in.

All serial inputs are brought into the system clock domain through a two-stage synchroniser. The decoded traffic is then presented on a plain register-file port: an address, write data, a one-cycle write strobe and combinational read data. Two registers live inside the block and are read-only. One is an identification register holding a device code. The other is a revision register whose field values are set by parameters. A parameter mask tells the block which of the remaining addresses the external register file implements.

Top module: `spireg_slave`

## Requirements
- R1: After reset, `spi_miso` is 0 and `reg_we` is 0.
- R2: A frame with bit 31 = 1 (write) and exactly 32 received bits produces exactly one single-cycle `reg_we` pulse. During that pulse, `reg_addr` equals frame bits 30:25 and `reg_wdata` equals frame bits 23:0.
- R3: `spi_miso` returns a 32-bit word MSB first, with each bit valid before the rising clock edge on which the host samples it. Bits 31:24 of the returned word are 0. Bits 23:0 hold the register addressed by bits 30:25 of the same frame.
- R4: Address 46 is the identification register. It reads 0x000080, which is device code 2 in bits 8:6 with every other bit 0.
- R5: Address 7 is the revision register. Its fields are: metal revision in bits 2:0, full revision in 4:3, IC id in 8:6, fin in 10:9, fab in 12:11 and id code in 18:13. All other bits are 0. With the default parameters it reads 0x00B299.
- R6: A write frame to address 7 or 46 produces no `reg_we`, and both registers keep their read value.
- R7: An address whose bit in the implemented-address mask is 0 (by default, addresses 32 to 63 apart from 46) reads as 0 whatever `reg_rdata` holds, and a write to it produces no `reg_we`.
- R8: A frame cut short by select falling before the 32nd bit produces no `reg_we`, and the next full frame decodes normally.
- R9: Frame bit 24 has no effect. A write with it set stores the same data. A read frame (bit 31 = 0) produces no `reg_we`, whatever its payload bits hold.
- R10: While select is low, `spi_miso` is 0 and serial clock activity is ignored: no strobe is produced and the next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs | input | 1 | Select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 6 | Register-file address |
| reg_wdata | output | 24 | Register-file write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 24 | Register-file read data for `reg_addr` |

## Verification
Suppose the bit counter or the latched address is wrong. That fault appears at `spi_miso` in the same frame, because the returned bits 23:0 are sampled by the host before the frame ends. A counter that is off by one shifts the whole returned word by a bit position. A miscounted or stale frame state shows up as a missing, doubled or misaddressed `reg_we` pulse within a few system clocks of the 32nd rising edge. The bench therefore compares every returned word bit for bit and counts strobes around each frame. A leak between frames is caught by the frame that follows a truncated or deselected sequence.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
   localparam int FLD_W = 24;

   // Revision word layout: [2:0] metal, [4:3] full, [8:6] IC id,
   // [10:9] fin, [12:11] fab, [18:13] id code, remaining bits zero.
   function automatic logic [FLD_W-1:0] pack_revision(
      input logic [2:0] metal,
      input logic [1:0] full,
      input logic [2:0] icid,
      input logic [1:0] fin,
      input logic [1:0] fab,
      input logic [5:0] code);
      return {5'b0, code, fab, fin, icid, 1'b0, full, metal};
   endfunction

   function automatic logic [FLD_W-1:0] pack_ident(input logic [2:0] dev);
      return {15'b0, dev, 6'b0};
   endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spireg_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sck,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata,
   output logic              is_write,
   output logic              done,
   output logic              sdo
);
   localparam int FRAME_W = 2 + ADDR_W + DATA_W;
   localparam int HDR_W   = 1 + ADDR_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_W);
   localparam logic [CNT_W-1:0] C_OUT0  = CNT_W'(FRAME_W - DATA_W);
   localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(FRAME_W);

   logic [FRAME_W-1:0] sr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [DATA_W-1:0]  rd_q;
   logic               sck_d;
   logic               rise, fall;
   logic [CNT_W-1:0]   out_idx;
   logic [DATA_W-1:0]  rd_shift;

   assign rise     = sck & ~sck_d;
   assign fall     = ~sck & sck_d;
   assign out_idx  = C_LAST - cnt_q;
   assign rd_shift = rd_q >> out_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         rd_q   <= '0;
         addr_q <= '0;
         sck_d  <= 1'b0;
         done   <= 1'b0;
         sdo    <= 1'b0;
      end else begin
         sck_d <= sck;
         done  <= 1'b0;
         if (!sel) begin
            cnt_q <= '0;
            sdo   <= 1'b0;
         end else begin
            if (rise && cnt_q != C_FULL) begin
               sr_q  <= {sr_q[FRAME_W-2:0], sdi};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == C_LAST) done <= 1'b1;
            end
            if (cnt_q == C_HDR) begin
               addr_q <= sr_q[ADDR_W-1:0];
               rd_q   <= rd_word;
            end
            if (fall)
               sdo <= (cnt_q >= C_OUT0 && cnt_q <= C_LAST) ? rd_shift[0] : 1'b0;
         end
      end
   end

   assign wdata    = sr_q[DATA_W-1:0];
   assign is_write = sr_q[FRAME_W-1];

   logic unused_hdr;
   assign unused_hdr = ^sr_q[FRAME_W-2:DATA_W];

   AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cnt_q == C_FULL && sel)) else $error("done without full frame"); // R8
   AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !fall) |=> $stable(sdo)) else $error("miso moved off a falling edge"); // R3
   AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !sdo) else $error("miso active while deselected"); // R10
endmodule

// File: rtl/spireg_regmap.sv
module spireg_regmap
   import spireg_pkg::*;
#(
   parameter int                   ADDR_W    = 6,
   parameter int                   DATA_W    = 24,
   parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 64'h0000_0000_FFFF_FFFF,
   parameter int                   ID_ADDR   = 46,
   parameter int                   REV_ADDR  = 7,
   parameter logic [DATA_W-1:0]    ID_VAL    = '0,
   parameter logic [DATA_W-1:0]    REV_VAL   = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic [DATA_W-1:0] rd_word,
   output logic              wr_ok
);
   localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(ID_ADDR);
   localparam logic [ADDR_W-1:0] A_REV = ADDR_W'(REV_ADDR);

   logic fixed_hit;
   assign fixed_hit = (addr == A_ID) || (addr == A_REV);

   always_comb begin
      if (addr == A_ID)         rd_word = ID_VAL;
      else if (addr == A_REV)   rd_word = REV_VAL;
      else if (IMPL_MASK[addr]) rd_word = ext_rdata;
      else                      rd_word = '0;
   end

   assign wr_ok = IMPL_MASK[addr] && !fixed_hit;
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
   import spireg_pkg::*;
#(
   parameter int                     ADDR_W    = 6,
   parameter int                     DATA_W    = 24,
   parameter int                     SYNC_STG  = 2,
   parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 64'h0000_0000_FFFF_FFFF,
   parameter int                     ID_ADDR   = 46,
   parameter int                     REV_ADDR  = 7,
   parameter logic [2:0]             DEV_CODE  = 3'd2,
   parameter logic [2:0]             REV_METAL = 3'd1,
   parameter logic [1:0]             REV_FULL  = 2'd3,
   parameter logic [1:0]             REV_FIN   = 2'd1,
   parameter logic [1:0]             REV_FAB   = 2'd2,
   parameter logic [5:0]             REV_CODE  = 6'd5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata
);
   localparam int NREG = 1 << ADDR_W;
   localparam logic [DATA_W-1:0] ID_VAL  = DATA_W'(pack_ident(DEV_CODE));
   localparam logic [DATA_W-1:0] REV_VAL = DATA_W'(pack_revision(
      REV_METAL, REV_FULL, DEV_CODE, REV_FIN, REV_FAB, REV_CODE));

   if (ADDR_W + DATA_W + 2 != 32) begin : g_bad_frame
      $error("frame must total 32 bits");
   end
   if (DATA_W != FLD_W) begin : g_bad_data
      $error("data width must match the revision layout");
   end
   if (ID_ADDR >= NREG || REV_ADDR >= NREG || ID_ADDR == REV_ADDR) begin : g_bad_addr
      $error("fixed register addresses out of range or equal");
   end

   logic       sel_s, sck_s, sdi_s;
   logic [DATA_W-1:0] rd_word;
   logic       wr_ok, is_write, done;

   spireg_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs, spi_sck, spi_mosi}),
      .q     ({sel_s, sck_s, sdi_s})
   );

   spireg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel_s),
      .sck      (sck_s),
      .sdi      (sdi_s),
      .rd_word  (rd_word),
      .addr_q   (reg_addr),
      .wdata    (reg_wdata),
      .is_write (is_write),
      .done     (done),
      .sdo      (spi_miso)
   );

   spireg_regmap #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK),
      .ID_ADDR(ID_ADDR), .REV_ADDR(REV_ADDR), .ID_VAL(ID_VAL), .REV_VAL(REV_VAL)
   ) u_regmap (
      .addr      (reg_addr),
      .ext_rdata (reg_rdata),
      .rd_word   (rd_word),
      .wr_ok     (wr_ok)
   );

   assign reg_we = done & is_write & wr_ok;

   AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we) else $error("write strobe longer than one cycle"); // R2
   AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> sel_s) else $error("write strobe outside a frame"); // R8
   AST_WE_NOT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_addr != ADDR_W'(ID_ADDR) && reg_addr != ADDR_W'(REV_ADDR)))
      else $error("write strobe to a read-only register"); // R6
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!reg_we && !spi_miso)) else $error("outputs active in reset"); // R1
endmodule

// File: tb/test_spireg_slave.sv
module test_spireg_slave;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
   logic        spi_miso;
   logic [5:0]  reg_addr;
   logic [23:0] reg_wdata, reg_rdata;
   logic        reg_we;

   logic [23:0] mem [64];
   int          n_tests = 0, n_fail = 0, we_cnt = 0;
   logic [5:0]  we_addr;
   logic [23:0] we_data;

   always #10 clk = ~clk;

   spireg_slave i_spireg_slave (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs(spi_cs),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   always @(negedge clk) if (reg_we) begin
      we_cnt  <= we_cnt + 1;
      we_addr <= reg_addr;
      we_data <= reg_wdata;
      mem[reg_addr] <= reg_wdata;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
      rx = '0;
      spi_cs = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = tx[31-i];
         repeat (HALF) @(negedge clk);
         rx[31-i] = spi_miso;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_cs = 1'b0;
      spi_mosi = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [31:0] wr_frame(input logic [5:0] a, input logic [23:0] d);
      return {1'b1, a, 1'b0, d};
   endfunction
   function automatic logic [31:0] rd_frame(input logic [5:0] a);
      return {1'b0, a, 1'b0, 24'h0};
   endfunction

   task automatic t_reset;
      chk(spi_miso == 1'b0, "R1 miso", {31'b0, spi_miso}, 0);
      chk(reg_we == 1'b0 && we_cnt == 0, "R1 we", we_cnt, 0);
   endtask

   task automatic t_write_read;
      logic [31:0] rx;
      int c0;
      c0 = we_cnt;
      xfer(wr_frame(6'd5, 24'hA5C3F0), 32, rx);
      chk(we_cnt == c0 + 1, "R2 strobe count", we_cnt - c0, 1);
      chk(we_addr == 6'd5, "R2 addr", {26'b0, we_addr}, 5);
      chk(we_data == 24'hA5C3F0, "R2 data", {8'b0, we_data}, 32'hA5C3F0);
      chk(rx[31:24] == 8'h0, "R3 header zero on write", rx, 0);
      xfer(rd_frame(6'd5), 32, rx);
      chk(rx == 32'h00A5C3F0, "R3 readback", rx, 32'h00A5C3F0);
      xfer(wr_frame(6'd31, 24'h5A0F81), 32, rx);
      xfer(rd_frame(6'd31), 32, rx);
      chk(rx == 32'h005A0F81, "R3 readback addr 31", rx, 32'h005A0F81);
      xfer(rd_frame(6'd12), 32, rx);
      chk(rx == {8'h0, 24'(12 * 24'h010203)}, "R3 preset addr 12", rx, {8'h0, 24'(12 * 24'h010203)});
   endtask

   task automatic t_fixed;
      logic [31:0] rx, rev;
      int c0;
      rev = (32'd1) | (32'd3 << 3) | (32'd2 << 6) | (32'd1 << 9) | (32'd2 << 11) | (32'd5 << 13);
      xfer(rd_frame(6'd46), 32, rx);
      chk(rx == 32'h80, "R4 ident", rx, 32'h80);
      chk(rx[8:6] == 3'd2, "R4 device code", {29'b0, rx[8:6]}, 2);
      xfer(rd_frame(6'd7), 32, rx);
      chk(rx == rev, "R5 revision", rx, rev);
      chk(rx == 32'h00B299, "R5 revision constant", rx, 32'h00B299);
      c0 = we_cnt;
      xfer(wr_frame(6'd7, 24'hFFFFFF), 32, rx);
      xfer(wr_frame(6'd46, 24'h123456), 32, rx);
      chk(we_cnt == c0, "R6 no strobe", we_cnt - c0, 0);
      xfer(rd_frame(6'd7), 32, rx);
      chk(rx == rev, "R6 revision kept", rx, rev);
      xfer(rd_frame(6'd46), 32, rx);
      chk(rx == 32'h80, "R6 ident kept", rx, 32'h80);
   endtask

   task automatic t_unimpl;
      logic [31:0] rx;
      int c0;
      xfer(rd_frame(6'd40), 32, rx);
      chk(rx == 0, "R7 unimplemented reads zero", rx, 0);
      c0 = we_cnt;
      xfer(wr_frame(6'd63, 24'h777777), 32, rx);
      chk(we_cnt == c0, "R7 no strobe", we_cnt - c0, 0);
   endtask

   task automatic t_trunc;
      logic [31:0] rx;
      int c0;
      c0 = we_cnt;
      xfer(wr_frame(6'd9, 24'h111111), 20, rx);
      xfer(wr_frame(6'd9, 24'h222222), 31, rx);
      chk(we_cnt == c0, "R8 truncated no strobe", we_cnt - c0, 0);
      xfer(rd_frame(6'd9), 32, rx);
      chk(rx == {8'h0, 24'(9 * 24'h010203)}, "R8 register untouched", rx, {8'h0, 24'(9 * 24'h010203)});
      xfer(wr_frame(6'd9, 24'h333333), 32, rx);
      chk(we_cnt == c0 + 1 && we_data == 24'h333333, "R8 next frame", {8'h0, we_data}, 32'h333333);
   endtask

   task automatic t_bit24;
      logic [31:0] rx;
      int c0;
      c0 = we_cnt;
      xfer({1'b1, 6'd3, 1'b1, 24'hC0FFEE}, 32, rx);
      chk(we_cnt == c0 + 1 && we_addr == 6'd3 && we_data == 24'hC0FFEE, "R9 write with bit 24", {8'h0, we_data}, 32'hC0FFEE);
      c0 = we_cnt;
      xfer({1'b0, 6'd3, 1'b1, 24'h123456}, 32, rx);
      chk(rx == 32'h00C0FFEE, "R9 read with bit 24", rx, 32'h00C0FFEE);
      chk(we_cnt == c0, "R9 read no strobe", we_cnt - c0, 0);
   endtask

   task automatic t_idle;
      logic [31:0] rx;
      int c0, bad;
      c0 = we_cnt;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         spi_mosi = 1'b1;
         repeat (4) @(negedge clk);
         spi_sck = 1'b1;
         repeat (4) @(negedge clk);
         spi_sck = 1'b0;
         if (spi_miso) bad++;
      end
      spi_mosi = 1'b0;
      chk(bad == 0, "R10 miso low while deselected", bad, 0);
      chk(we_cnt == c0, "R10 no strobe", we_cnt - c0, 0);
      xfer(rd_frame(6'd3), 32, rx);
      chk(rx == 32'h00C0FFEE, "R10 next frame", rx, 32'h00C0FFEE);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 24'(i * 24'h010203);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_write_read();
      t_fixed();
      t_unimpl();
      t_trunc();
      t_bit24();
      t_idle();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule